// File: doc/BRIEF.md
# Multilevel Interrupt Enable Controller

This block combines interrupt requests from four priority levels and a stack-overflow request into one interrupt signal for an 8-bit processor core. Each level has an enable flag, and a master enable flag gates every level and the stack-overflow source. The processor changes flags with two commands. A set command writes a value into the flag chosen by a 3-bit select code. A pulse command raises the chosen flag for one cycle only.

When a request is accepted, the block raises the interrupt output and reports the accepted level in encoded form. In the same clock edge it clears the enables of all lower-priority levels and the master enable. It also saves the stored enables as they stood just before acceptance. A return-from-interrupt input restores the saved enables. Several devices can share a level's request line through an external wire-OR, because any high request counts.

Top module: `mlic_top`

## Requirements
- R1: While `sys_clr` is high, every level enable, the master enable and all pending state clear at each clock edge. Afterwards `int_o` is 0, `int_lvl` is 0, and `lvl_en` and `mst_en` are 0.
- R2: A set command (`flg_set`) with select code 0..3 writes `flg_val` into the enable of level code+1, which appears on bit `code` of `lvl_en`. Select code 4 writes the master enable.
- R3: Set or pulse commands with select codes 5, 6 or 7 change no flag.
- R4: A pulse command (`flg_pulse`) makes the selected flag read 1 for exactly the one cycle after the command edge. The flag then returns to its stored value.
- R5: A request is accepted only if its line is high (active high), its level enable reads 1 and the master enable reads 1. The stack-overflow request needs only the master enable.
- R6: Priority: stack overflow is highest, then level 1 (`lvl_req[0]`), down to level 4 (`lvl_req[3]`), which is lowest.
- R7: On acceptance of level k, the enables of all levels numbered above k clear in the same edge, and those of level k and higher levels are kept. Acceptance of stack overflow clears all level enables.
- R8: On acceptance, the master enable clears. The stored level and master enables from before acceptance are saved, and pulse effects are not included. A `rti` pulse restores both saved values.
- R9: `int_o` stays high and `int_lvl` stays unchanged until a cycle with `int_ack` high. After that cycle `int_o` is 0. `int_lvl` uses 0 for idle, 1..4 for request levels and 5 for stack overflow.
- R10: In an edge where a request is accepted, set, pulse and `rti` inputs are dropped. In an edge with `rti` and no acceptance, set and pulse commands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_clr | input | 1 | Synchronous system clear, active high |
| flg_set | input | 1 | Set-flag command strobe |
| flg_pulse | input | 1 | Pulse-flag command strobe |
| flg_sel | input | 3 | Flag select code |
| flg_val | input | 1 | Value written by a set command |
| lvl_req | input | 4 | Level request lines, bit 0 = level 1 |
| stk_ovf_req | input | 1 | Stack-overflow request |
| int_ack | input | 1 | Interrupt acknowledge |
| rti | input | 1 | Return from interrupt: restore saved enables |
| int_o | output | 1 | Interrupt to the processor |
| int_lvl | output | 3 | Encoded accepted source (0 idle, 1..4 level, 5 overflow) |
| lvl_en | output | 4 | Effective level enables |
| mst_en | output | 1 | Effective master enable |

## Verification
The gating is tried in three ways: with each single request alone, with several requests raised together including the overflow source, and with requests held while either the master or the level enable is off. The single requests confirm which lower-level enables clear on acceptance. The raised-together requests separate a correct priority order from a reversed one. The held requests show that no gating term has been left out. The remaining tests cover the timing of the commands and state restore. Pulses are tested both with and without a waiting request, which checks the one-cycle window and confirms that pulse effects are excluded from the saved state. Commands issued in the same edge as an acceptance or a `rti` check the arbitration rules of R10.

// File: rtl/mlic_pkg.sv
package mlic_pkg;
    parameter int NUM_LVL = 4;
    parameter int SEL_W   = 3;
    localparam int CODE_W = $clog2(NUM_LVL + 2);
    localparam logic [CODE_W-1:0] CODE_IDLE = '0;
    localparam logic [CODE_W-1:0] CODE_OVF  = CODE_W'(NUM_LVL + 1);

    typedef struct packed {
        logic [NUM_LVL-1:0] en;
        logic               mst;
        logic [NUM_LVL-1:0] pls_en;
        logic               pls_mst;
        logic               irq;
        logic [CODE_W-1:0]  code;
        logic [NUM_LVL-1:0] sav_en;
        logic               sav_mst;
    } mlic_state_t;
endpackage

// File: rtl/mlic_flag_dec.sv
module mlic_flag_dec #(
    parameter int NUM_LVL = 4,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_LVL-1:0] lvl_hit,
    output logic               mst_hit
);
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_hit
        assign lvl_hit[i] = (sel == SEL_W'(i));
    end
    assign mst_hit = (sel == SEL_W'(NUM_LVL));
endmodule

// File: rtl/mlic_prio.sv
module mlic_prio #(
    parameter int NUM_LVL = 4,
    parameter int CODE_W  = 3
) (
    input  logic [NUM_LVL-1:0] live,
    input  logic               ovf_live,
    output logic               any,
    output logic [CODE_W-1:0]  code,
    output logic [NUM_LVL-1:0] keep
);
    logic [NUM_LVL-1:0] keep_lvl;

    assign keep_lvl[0] = 1'b1;
    for (genvar j = 1; j < NUM_LVL; j++) begin : g_keep
        assign keep_lvl[j] = ~|live[j-1:0];
    end

    always_comb begin
        code = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (live[i]) code = CODE_W'(i + 1);
        end
        if (ovf_live) code = CODE_W'(NUM_LVL + 1);
        any  = ovf_live | (|live);
        keep = ovf_live ? '0 : keep_lvl;
    end
endmodule

// File: rtl/mlic_top.sv
module mlic_top
    import mlic_pkg::*;
(
    input  logic               clk,
    input  logic               sys_clr,
    input  logic               flg_set,
    input  logic               flg_pulse,
    input  logic [SEL_W-1:0]   flg_sel,
    input  logic               flg_val,
    input  logic [NUM_LVL-1:0] lvl_req,
    input  logic               stk_ovf_req,
    input  logic               int_ack,
    input  logic               rti,
    output logic               int_o,
    output logic [CODE_W-1:0]  int_lvl,
    output logic [NUM_LVL-1:0] lvl_en,
    output logic               mst_en
);
    mlic_state_t st_d, st_q;

    logic [NUM_LVL-1:0] hit_lvl, live, keep;
    logic               hit_mst, any;
    logic [CODE_W-1:0]  win_code;
    logic [NUM_LVL-1:0] en_eff;
    logic               mst_eff, accept;

    mlic_flag_dec #(.NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) i_dec (
        .sel     (flg_sel),
        .lvl_hit (hit_lvl),
        .mst_hit (hit_mst)
    );

    assign en_eff  = st_q.en | st_q.pls_en;
    assign mst_eff = st_q.mst | st_q.pls_mst;
    assign live    = lvl_req & en_eff & {NUM_LVL{mst_eff}};

    mlic_prio #(.NUM_LVL(NUM_LVL), .CODE_W(CODE_W)) i_prio (
        .live     (live),
        .ovf_live (stk_ovf_req & mst_eff),
        .any      (any),
        .code     (win_code),
        .keep     (keep)
    );

    assign accept = ~st_q.irq & any;

    always_comb begin
        st_d         = st_q;
        st_d.pls_en  = '0;
        st_d.pls_mst = 1'b0;
        if (st_q.irq && int_ack) begin
            st_d.irq  = 1'b0;
            st_d.code = CODE_IDLE;
        end
        if (accept) begin
            st_d.irq     = 1'b1;
            st_d.code    = win_code;
            st_d.sav_en  = st_q.en;
            st_d.sav_mst = st_q.mst;
            st_d.en      = st_q.en & keep;
            st_d.mst     = 1'b0;
        end else if (rti) begin
            st_d.en  = st_q.sav_en;
            st_d.mst = st_q.sav_mst;
        end else begin
            if (flg_set) begin
                st_d.en = (st_q.en & ~hit_lvl) | (hit_lvl & {NUM_LVL{flg_val}});
                if (hit_mst) st_d.mst = flg_val;
            end
            if (flg_pulse) begin
                st_d.pls_en  = hit_lvl;
                st_d.pls_mst = hit_mst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (sys_clr) st_q <= '0;
        else         st_q <= st_d;
    end

    assign int_o   = st_q.irq;
    assign int_lvl = st_q.code;
    assign lvl_en  = en_eff;
    assign mst_en  = mst_eff;
endmodule

// File: rtl/mlic_chk.sv
module mlic_chk
    import mlic_pkg::*;
(
    input logic               clk,
    input logic               sys_clr,
    input logic               int_ack,
    input logic               stk_ovf_req,
    input logic               int_o,
    input logic [CODE_W-1:0]  int_lvl,
    input logic [NUM_LVL-1:0] lvl_en,
    input logic               mst_en
);
    logic [NUM_LVL-1:0] low_m;

    always_comb begin
        for (int j = 0; j < NUM_LVL; j++) begin
            low_m[j] = (int_lvl == CODE_OVF) ||
                       ((int_lvl != CODE_IDLE) && (CODE_W'(j) >= int_lvl));
        end
    end

    a_r5_needs_master: assert property (@(posedge clk) disable iff (sys_clr)
        $rose(int_o) |-> $past(mst_en));

    a_r6_ovf_wins: assert property (@(posedge clk) disable iff (sys_clr)
        $rose(int_o) |-> ((int_lvl == CODE_OVF) == $past(stk_ovf_req)));

    a_r7_lower_cleared: assert property (@(posedge clk) disable iff (sys_clr)
        $rose(int_o) |-> ((lvl_en & low_m) == '0));

    a_r8_master_dropped: assert property (@(posedge clk) disable iff (sys_clr)
        $rose(int_o) |-> !mst_en);

    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (sys_clr)
        (int_o && !int_ack) |=> (int_o && $stable(int_lvl)));

    a_r9_idle_code: assert property (@(posedge clk) disable iff (sys_clr)
        !int_o |-> (int_lvl == CODE_IDLE));
endmodule

bind mlic_top mlic_chk i_chk (
    .clk         (clk),
    .sys_clr     (sys_clr),
    .int_ack     (int_ack),
    .stk_ovf_req (stk_ovf_req),
    .int_o       (int_o),
    .int_lvl     (int_lvl),
    .lvl_en      (lvl_en),
    .mst_en      (mst_en)
);

// File: tb/test_mlic_top.sv
module test_mlic_top;
    logic       clk = 1'b0;
    logic       sys_clr = 1'b1;
    logic       flg_set = 1'b0, flg_pulse = 1'b0, flg_val = 1'b0;
    logic [2:0] flg_sel = '0;
    logic [3:0] lvl_req = '0;
    logic       stk_ovf_req = 1'b0, int_ack = 1'b0, rti = 1'b0;
    logic       int_o, mst_en;
    logic [2:0] int_lvl;
    logic [3:0] lvl_en;

    int checks = 0, failures = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mlic_top i_mlic_top (
        .clk(clk), .sys_clr(sys_clr), .flg_set(flg_set), .flg_pulse(flg_pulse),
        .flg_sel(flg_sel), .flg_val(flg_val), .lvl_req(lvl_req),
        .stk_ovf_req(stk_ovf_req), .int_ack(int_ack), .rti(rti),
        .int_o(int_o), .int_lvl(int_lvl), .lvl_en(lvl_en), .mst_en(mst_en)
    );

    // behavioural reference model
    logic [3:0] m_en, m_pe, m_sv;
    logic       m_mst, m_pm, m_svm, m_int;
    int         m_code;
    logic [3:0] pe;
    logic       pm;
    int         win;

    always @(posedge clk) begin
        if (sys_clr) begin
            m_en <= 0; m_pe <= 0; m_sv <= 0; m_mst <= 0; m_pm <= 0;
            m_svm <= 0; m_int <= 0; m_code <= 0;
        end else begin
            pe = m_en | m_pe;
            pm = m_mst | m_pm;
            win = 0;
            if (stk_ovf_req && pm) win = 5;
            else for (int i = 0; i < 4; i++)
                if (win == 0 && lvl_req[i] && pe[i] && pm) win = i + 1;
            m_pe <= 0; m_pm <= 0;
            if (m_int && int_ack) begin m_int <= 0; m_code <= 0; end
            if (!m_int && win != 0) begin
                m_int <= 1; m_code <= win; m_sv <= m_en; m_svm <= m_mst; m_mst <= 0;
                for (int i = 0; i < 4; i++) if (win == 5 || i + 1 > win) m_en[i] <= 0;
            end else if (rti) begin
                m_en <= m_sv; m_mst <= m_svm;
            end else begin
                if (flg_set) begin
                    if (flg_sel < 4) m_en[flg_sel[1:0]] <= flg_val;
                    else if (flg_sel == 4) m_mst <= flg_val;
                end
                if (flg_pulse) begin
                    if (flg_sel < 4) m_pe[flg_sel[1:0]] <= 1;
                    else if (flg_sel == 4) m_pm <= 1;
                end
            end
            started <= 1;
        end
    end

    always @(negedge clk) begin
        if (started && !sys_clr && !done) begin
            checks++;
            if (int_o !== m_int || int_lvl !== 3'(m_code) ||
                lvl_en !== (m_en | m_pe) || mst_en !== (m_mst | m_pm)) begin
                failures++;
                $display("FAIL R5 R9 model: int=%0b lvl=%0d en=%b mst=%0b expected int=%0b lvl=%0d en=%b mst=%0b",
                         int_o, int_lvl, lvl_en, mst_en, m_int, m_code, m_en | m_pe, m_mst | m_pm);
            end
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(string req, logic i, logic [2:0] c, logic [3:0] e, logic m);
        checks++;
        if (int_o !== i || int_lvl !== c || lvl_en !== e || mst_en !== m) begin
            failures++;
            $display("FAIL %s: int=%0b lvl=%0d en=%b mst=%0b expected int=%0b lvl=%0d en=%b mst=%0b",
                     req, int_o, int_lvl, lvl_en, mst_en, i, c, e, m);
        end
    endtask

    task automatic set_flag(logic [2:0] s, logic v);
        flg_set = 1; flg_sel = s; flg_val = v; step(); flg_set = 0;
    endtask

    task automatic pulse_flag(logic [2:0] s);
        flg_pulse = 1; flg_sel = s; step(); flg_pulse = 0;
    endtask

    task automatic ack_rti();
        int_ack = 1; step(); int_ack = 0;
        rti = 1; step(); rti = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); sys_clr = 0;
        check("R1 reset", 0, 0, 4'h0, 0);
        for (int s = 0; s < 5; s++) set_flag(3'(s), 1);
        check("R2 set all", 0, 0, 4'hF, 1);
        set_flag(6, 0); set_flag(7, 0); set_flag(5, 0);
        check("R3 bad codes", 0, 0, 4'hF, 1);
        // single request on level 3
        lvl_req = 4'b0100; step();
        check("R7 accept level 3", 1, 3, 4'b0111, 0);
        step(); step();
        check("R9 held", 1, 3, 4'b0111, 0);
        lvl_req = 0; int_ack = 1; step(); int_ack = 0;
        check("R9 ack", 0, 0, 4'b0111, 0);
        rti = 1; step(); rti = 0;
        check("R8 restore", 0, 0, 4'hF, 1);
        // priority
        lvl_req = 4'b1010; stk_ovf_req = 1; step();
        check("R6 overflow first", 1, 5, 4'h0, 0);
        stk_ovf_req = 0; ack_rti();
        check("R8 restore after overflow", 0, 0, 4'hF, 1);
        step();
        check("R6 level 2 over 4", 1, 2, 4'b0011, 0);
        lvl_req = 0; ack_rti();
        // gating
        set_flag(4, 0);
        for (int s = 0; s < 4; s++) set_flag(3'(s), 0);
        lvl_req = 4'hF; stk_ovf_req = 1; step(); step();
        check("R5 master off", 0, 0, 4'h0, 0);
        stk_ovf_req = 0; set_flag(4, 1); step();
        check("R5 levels off", 0, 0, 4'h0, 1);
        set_flag(2, 1); step();
        check("R5 enable level 3", 1, 3, 4'b0100, 0);
        lvl_req = 0; ack_rti();
        check("R8 restore 2", 0, 0, 4'b0100, 1);
        // pulses
        set_flag(2, 0);
        pulse_flag(1);
        check("R4 pulse on", 0, 0, 4'b0010, 1);
        step();
        check("R4 pulse off", 0, 0, 4'b0000, 1);
        pulse_flag(6);
        check("R3 bad pulse", 0, 0, 4'b0000, 1);
        set_flag(4, 0);
        pulse_flag(4);
        check("R4 master pulse", 0, 0, 4'b0000, 1);
        step();
        check("R4 master back", 0, 0, 4'b0000, 0);
        set_flag(4, 1);
        lvl_req = 4'b0010; pulse_flag(1);
        check("R4 pulse window", 0, 0, 4'b0010, 1);
        step();
        check("R5 accept via pulse", 1, 2, 4'b0000, 0);
        lvl_req = 0; ack_rti();
        check("R8 stored only", 0, 0, 4'b0000, 1);
        // arbitration
        for (int s = 0; s < 4; s++) set_flag(3'(s), 1);
        lvl_req = 4'b1000; flg_set = 1; flg_sel = 3; flg_val = 0; step(); flg_set = 0;
        check("R10 accept beats set", 1, 4, 4'hF, 0);
        lvl_req = 0; int_ack = 1; step(); int_ack = 0;
        rti = 1; flg_set = 1; flg_sel = 0; flg_val = 0; step(); rti = 0; flg_set = 0;
        check("R10 rti beats set", 0, 0, 4'hF, 1);
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL R9 watchdog: run=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule